// File: doc/BRIEF.md
# Bus Hold and Lock Arbiter

This block decides who owns a processor's external bus. Another bus master asks for the bus with a hold request. The arbiter lets the cycles already on the bus finish, then grants the bus: it raises hold acknowledge and drops the output enables. The core offers cycles one at a time. Each cycle is a request token that the arbiter launches with a one-clock address strobe, and a ready pulse from the memory system completes it. The arbiter counts the cycles that are in flight, so it knows when the bus is idle.

A locked sequence is a run of cycles that no other master may split. The arbiter drives the lock output for the whole sequence and refuses the hold request while lock is active. It also forces lock low for at least one clock between two locked sequences. When the memory system signals next-address, the arbiter can launch a second cycle before the first completes. When hold ends, a waiting cycle is launched in the same clock that hold acknowledge falls.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `rst_ni` is low, `hlda_o` equals `hold_req_i` and `bus_oe_o` equals its inverse. `ads_o` and `lock_o` stay low.
- R2: `hlda_o` rises only once no cycle is outstanding. If the ready for the last outstanding cycle arrives at a clock edge while a hold request is present, `hlda_o` is high from that edge on. `bus_oe_o` is always the inverse of `hlda_o`.
- R3: While `hlda_o` is high and `hold_req_i` stays high, the grant is kept and `ads_o` stays low, even if a request is waiting.
- R4: A hold request is not honoured in any clock whose edge sees `lock_o` high. The earliest grant comes one clock after `lock_o` has fallen.
- R5: When `hold_req_i` is sampled low during a grant, `hlda_o` falls at the next edge. If `req_valid_i` is high at that edge, `ads_o` is high in the same clock that `hlda_o` falls.
- R6: `lock_o` rises in the same clock as the strobe of a cycle whose `req_lock_i` is 1. It stays high across the following locked cycles. It falls at the edge that samples the ready of the cycle marked with `req_lock_end_i` = 1.
- R7: If a new locked request is already waiting when a locked sequence ends, `lock_o` and `ads_o` are both low for exactly one clock before the next locked strobe.
- R8: If `na_i` is sampled high while one cycle is outstanding, the next waiting cycle is strobed two clocks after the clock in which `na_i` was high. There are never more than two cycles outstanding: with two in flight, `na_i` launches nothing.
- R9: `mio_o` takes the `req_mio_i` value of a cycle in the clock that cycle's `ads_o` is high, and holds it in every other clock. Each accepted request produces exactly one strobe, in request order.
- R10: In the first clock after reset is released, `hlda_o` is low unless `hold_req_i` is still high, in which case the grant continues without a gap.
- R11: A ready pulse with no cycle outstanding is ignored. A later hold request still waits for the ready of the next strobed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Bus request from another master |
| rdy_i | input | 1 | Completes the oldest outstanding cycle |
| na_i | input | 1 | Next-address: memory can accept another cycle |
| req_valid_i | input | 1 | Core has a cycle waiting; it changes the request in the clock after `ads_o` |
| req_mio_i | input | 1 | Waiting cycle is memory (1) or I/O (0) |
| req_lock_i | input | 1 | Waiting cycle belongs to a locked sequence |
| req_lock_end_i | input | 1 | Waiting cycle is the last of its locked sequence |
| hlda_o | output | 1 | Hold acknowledge: bus released |
| bus_oe_o | output | 1 | Output enable for the bus drivers |
| ads_o | output | 1 | One-clock address strobe for a launched cycle |
| lock_o | output | 1 | Bus lock for a locked sequence |
| mio_o | output | 1 | Memory/I/O type of the last launched cycle |

## Verification
The outstanding count is the state most likely to go wrong, and an error in it shows at the bus within one or two clocks. If the count drifts upward, a hold grant never arrives. If it drifts downward, or wraps after an unmatched ready, the grant arrives while a cycle is still in flight. A wrong limit lets a third strobe out after next-address. A lock flag that clears early or late shows as a hold grant in the middle of a sequence, or as a missing one-clock gap. The bench runs a model of the outstanding count on every clock and checks a queue of expected strobes, so each of these errors is caught in the clock it happens.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  // per-cycle bookkeeping kept while a cycle is outstanding
  typedef struct packed {
    logic lock_end;
  } cyc_tag_t;
endpackage

// File: rtl/bus_own_track.sv
module bus_own_track
  import bus_own_pkg::*;
#(
  parameter  int unsigned MAX_OUT = 2,
  localparam int unsigned CW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  cyc_tag_t      push_tag_i,
  input  logic          rdy_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_after_o,
  output logic          pop_o,
  output cyc_tag_t      head_tag_o
);
  localparam int unsigned AW = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;

  cyc_tag_t        slot_q [MAX_OUT];
  logic [AW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(MAX_OUT - 1)) ? '0 : p + 1'b1;
  endfunction

  // ready with nothing in flight is dropped here
  assign pop_o       = rdy_i && (cnt_q != '0);
  assign cnt_after_o = cnt_q - CW'(pop_o);
  assign cnt_o       = cnt_q;
  assign head_tag_o  = slot_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_o)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_o);
    end
  end

  for (genvar i = 0; i < MAX_OUT; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q[i] <= '0;
      else if (push_i && (wr_q == AW'(i)))       slot_q[i] <= push_tag_i;
    end
  end
endmodule

// File: rtl/bus_own_lock.sv
module bus_own_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic issue_locked_i,
  input  logic pop_i,
  input  logic head_lock_end_i,
  output logic lock_o,
  output logic lock_clr_o
);
  logic lock_q;

  assign lock_clr_o = lock_q && pop_i && head_lock_end_i;
  assign lock_o     = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lock_q <= 1'b0;
    else if (lock_clr_o)                  lock_q <= 1'b0;
    else if (issue_i && issue_locked_i)   lock_q <= 1'b1;
  end
endmodule

// File: rtl/bus_own_hold.sv
module bus_own_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic lock_i,
  input  logic idle_i,
  output logic hlda_o,
  output logic hold_seen_o
);
  logic hlda_q, run_q;

  // request is invisible while the bus is locked
  assign hold_seen_o = hold_req_i && !lock_i;
  // until the first edge after reset the grant follows the request directly
  assign hlda_o      = run_q ? hlda_q : hold_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hlda_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      hlda_q <= hold_req_i && (hlda_q || (!lock_i && idle_i));
    end
  end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int unsigned MAX_OUT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic rdy_i,
  input  logic na_i,
  input  logic req_valid_i,
  input  logic req_mio_i,
  input  logic req_lock_i,
  input  logic req_lock_end_i,
  output logic hlda_o,
  output logic bus_oe_o,
  output logic ads_o,
  output logic lock_o,
  output logic mio_o
);
  localparam int unsigned CW = $clog2(MAX_OUT + 1);

  logic [CW-1:0] cnt, cnt_after;
  logic          pop, lock_clr, hold_seen;
  logic          issue, issue_idle, issue_pipe;
  logic          ads_q, na_arm_q, mio_q;
  cyc_tag_t      head_tag, new_tag;

  assign new_tag.lock_end = req_lock_i && req_lock_end_i;

  bus_own_track #(.MAX_OUT(MAX_OUT)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (issue),
    .push_tag_i (new_tag),
    .rdy_i      (rdy_i),
    .cnt_o      (cnt),
    .cnt_after_o(cnt_after),
    .pop_o      (pop),
    .head_tag_o (head_tag)
  );

  bus_own_lock u_lock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .issue_i        (issue),
    .issue_locked_i (req_lock_i),
    .pop_i          (pop),
    .head_lock_end_i(head_tag.lock_end),
    .lock_o         (lock_o),
    .lock_clr_o     (lock_clr)
  );

  bus_own_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_req_i (hold_req_i),
    .lock_i     (lock_o),
    .idle_i     (issue_idle),
    .hlda_o     (hlda_o),
    .hold_seen_o(hold_seen)
  );

  assign issue_idle = (cnt_after == '0);
  // next-address launch: not inside a locked sequence, and only below the limit
  assign issue_pipe = na_arm_q && !lock_o && (cnt_after < CW'(MAX_OUT));
  // ads_q blocks a re-launch of the request just strobed; lock_clr forces the lock gap
  assign issue = req_valid_i && !ads_q && !hold_seen && !lock_clr &&
                 (issue_idle || issue_pipe);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ads_q    <= 1'b0;
      na_arm_q <= 1'b0;
      mio_q    <= 1'b0;
    end else begin
      ads_q    <= issue;
      na_arm_q <= na_i && (cnt != '0);
      if (issue) mio_q <= req_mio_i;
    end
  end

  assign ads_o    = ads_q;
  assign mio_o    = mio_q;
  assign bus_oe_o = !hlda_o;
endmodule

module bus_own_ctrl_chk #(
  parameter  int unsigned MAX_OUT = 2,
  localparam int unsigned CW      = $clog2(MAX_OUT + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_req_i,
  input logic          rdy_i,
  input logic          req_valid_i,
  input logic          hlda_o,
  input logic          ads_o,
  input logic          lock_o,
  input logic          mio_o,
  input logic [CW-1:0] cnt_i,
  input logic          head_end_i
);
  a_r1_reset_outputs: assert property (@(posedge clk_i)
    !rst_ni |-> (hlda_o == hold_req_i) && !ads_o && !lock_o);

  a_r2_grant_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> (cnt_i == '0));

  a_r3_no_strobe_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hlda_o && ads_o));

  a_r4_lock_blocks_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> !hlda_o);

  a_r5_strobe_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) && $past(req_valid_i) |-> ads_o);

  a_r6_lock_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ads_o);

  a_r7_lock_drops_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && rdy_i && (cnt_i != '0) && head_end_i |=> !lock_o);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(MAX_OUT));

  a_r9_mio_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_o |-> $stable(mio_o));

  a_r11_idle_ready_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (cnt_i == CW'(ads_o)));
endmodule

bind bus_own_ctrl bus_own_ctrl_chk #(.MAX_OUT(MAX_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_req_i (hold_req_i),
  .rdy_i      (rdy_i),
  .req_valid_i(req_valid_i),
  .hlda_o     (hlda_o),
  .ads_o      (ads_o),
  .lock_o     (lock_o),
  .mio_o      (mio_o),
  .cnt_i      (cnt),
  .head_end_i (head_tag.lock_end)
);

// File: tb/bus_own_ctrl_test.sv
module bus_own_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, hold_req_i, rdy_i, na_i;
  logic req_valid_i, req_mio_i, req_lock_i, req_lock_end_i;
  logic hlda_o, bus_oe_o, ads_o, lock_o, mio_o;

  bus_own_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .hold_req_i(hold_req_i), .rdy_i(rdy_i), .na_i(na_i),
    .req_valid_i(req_valid_i), .req_mio_i(req_mio_i), .req_lock_i(req_lock_i),
    .req_lock_end_i(req_lock_end_i), .hlda_o(hlda_o), .bus_oe_o(bus_oe_o),
    .ads_o(ads_o), .lock_o(lock_o), .mio_o(mio_o)
  );

  int n_run = 0, n_fail = 0;
  bit exp_q[$];
  int model_cnt = 0;
  logic rdy_smp = 1'b0;
  logic mio_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: queue the expected strobe, present the request
  task automatic post(input bit mio, input bit lk, input bit last);
    exp_q.push_back(mio);
    req_valid_i    = 1'b1;
    req_mio_i      = mio;
    req_lock_i     = lk;
    req_lock_end_i = last;
  endtask

  task automatic wait_ads(input string req);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (ads_o) return;
    end
    check(1'b0, req, 0, 1);
  endtask

  always @(posedge clk) rdy_smp <= rdy_i;

  // monitor: scoreboard pop plus outstanding-count model
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ads_o) begin
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected strobe", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          check(mio_o == e, "R9 strobe type", int'(mio_o), int'(e));
        end
      end else begin
        check(mio_o == mio_prev, "R9 type held", int'(mio_o), int'(mio_prev));
      end
      model_cnt = model_cnt - ((rdy_smp && model_cnt > 0) ? 1 : 0) + (ads_o ? 1 : 0);
      check(model_cnt <= 2, "R8 outstanding limit", model_cnt, 2);
      if (hlda_o) check(model_cnt == 0, "R2 grant only when idle", model_cnt, 0);
      check(!(hlda_o && ads_o), "R3 no strobe while granted", int'(ads_o), 0);
      check(bus_oe_o == !hlda_o, "R2 enable inverse of grant", int'(bus_oe_o), int'(!hlda_o));
      mio_prev = mio_o;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 5000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; hold_req_i = 1'b1; rdy_i = 1'b0; na_i = 1'b0;
    req_valid_i = 1'b0; req_mio_i = 1'b0; req_lock_i = 1'b0; req_lock_end_i = 1'b0;
    repeat (2) tick();
    check(hlda_o == 1'b1, "R1 grant follows request in reset", int'(hlda_o), 1);
    check(bus_oe_o == 1'b0, "R1 enables off in reset", int'(bus_oe_o), 0);
    hold_req_i = 1'b0; #1;
    check(hlda_o == 1'b0, "R1 grant drops with request", int'(hlda_o), 0);
    check(!ads_o && !lock_o, "R1 strobe and lock low", int'(ads_o | lock_o), 0);
    tick(); rst_ni = 1'b1;
    tick();
    check(hlda_o == 1'b0, "R10 no grant after reset", int'(hlda_o), 0);

    // R11: spurious ready, then hold must still wait for the strobed cycle
    rdy_i = 1'b1; tick(); tick(); rdy_i = 1'b0;
    post(1'b1, 1'b0, 1'b0); wait_ads("R9 first strobe"); req_valid_i = 1'b0;
    hold_req_i = 1'b1;
    tick(); check(hlda_o == 1'b0, "R2 grant waits for ready", int'(hlda_o), 0);
    tick(); check(hlda_o == 1'b0, "R11 idle ready ignored", int'(hlda_o), 0);
    rdy_i = 1'b1; tick(); rdy_i = 1'b0;
    check(hlda_o == 1'b1, "R2 grant at last ready", int'(hlda_o), 1);
    check(bus_oe_o == 1'b0, "R2 enables off on grant", int'(bus_oe_o), 0);

    // R3 / R5
    post(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick();
      check(hlda_o && !ads_o, "R3 grant held, no strobe", int'(ads_o), 0);
    end
    hold_req_i = 1'b0; tick();
    check(hlda_o == 1'b0, "R5 grant released", int'(hlda_o), 0);
    check(ads_o == 1'b1, "R5 strobe as grant falls", int'(ads_o), 1);
    req_valid_i = 1'b0; rdy_i = 1'b1; tick(); rdy_i = 1'b0;

    // R6 / R4: two-cycle locked sequence with hold pending
    post(1'b1, 1'b1, 1'b0); wait_ads("R6 locked strobe");
    check(lock_o == 1'b1, "R6 lock with first strobe", int'(lock_o), 1);
    req_valid_i = 1'b0; hold_req_i = 1'b1;
    rdy_i = 1'b1; tick(); rdy_i = 1'b0;
    check(lock_o == 1'b1, "R6 lock kept between cycles", int'(lock_o), 1);
    check(hlda_o == 1'b0, "R4 hold refused under lock", int'(hlda_o), 0);
    post(1'b0, 1'b1, 1'b1); wait_ads("R4 strobe despite hold under lock");
    req_valid_i = 1'b0;
    check(hlda_o == 1'b0, "R4 no grant during lock", int'(hlda_o), 0);
    tick(); check(lock_o == 1'b1, "R6 lock until last ready", int'(lock_o), 1);
    rdy_i = 1'b1; tick(); rdy_i = 1'b0;
    check(lock_o == 1'b0, "R6 lock drops after last ready", int'(lock_o), 0);
    check(hlda_o == 1'b0, "R4 grant not in lock-drop clock", int'(hlda_o), 0);
    tick(); check(hlda_o == 1'b1, "R4 grant after lock", int'(hlda_o), 1);
    hold_req_i = 1'b0; tick();
    check(hlda_o == 1'b0, "R5 release without request", int'(hlda_o), 0);

    // R7: back-to-back locked sequences
    post(1'b1, 1'b1, 1'b1); wait_ads("R7 first sequence");
    post(1'b0, 1'b1, 1'b1);
    tick(); rdy_i = 1'b1;
    tick(); rdy_i = 1'b0;
    check(lock_o == 1'b0, "R7 lock gap", int'(lock_o), 0);
    check(ads_o == 1'b0, "R7 no strobe in gap", int'(ads_o), 0);
    tick();
    check(ads_o && lock_o, "R7 next sequence after gap", int'(ads_o & lock_o), 1);
    req_valid_i = 1'b0; rdy_i = 1'b1; tick(); rdy_i = 1'b0; tick();
    check(lock_o == 1'b0, "R6 lock released", int'(lock_o), 0);

    // R8: next-address pipelining and the two-cycle limit
    post(1'b1, 1'b0, 1'b0); wait_ads("R8 first cycle");
    post(1'b0, 1'b0, 1'b0); na_i = 1'b1; tick(); na_i = 1'b0;
    check(ads_o == 1'b0, "R8 no strobe one clock after NA", int'(ads_o), 0);
    tick(); check(ads_o == 1'b1, "R8 strobe two clocks after NA", int'(ads_o), 1);
    post(1'b1, 1'b0, 1'b0); na_i = 1'b1; tick(); na_i = 1'b0;
    tick(); check(ads_o == 1'b0, "R8 third cycle held at limit", int'(ads_o), 0);
    rdy_i = 1'b1; tick();
    check(ads_o == 1'b0, "R8 no launch without NA", int'(ads_o), 0);
    tick(); check(ads_o == 1'b1, "R8 launch once drained", int'(ads_o), 1);
    req_valid_i = 1'b0; tick(); rdy_i = 1'b0; tick();

    // R10: hold kept across reset exit
    rst_ni = 1'b0; hold_req_i = 1'b1;
    tick(); tick();
    model_cnt = 0; mio_prev = 1'b0;
    rst_ni = 1'b1; #1;
    check(hlda_o == 1'b1, "R10 grant at reset exit", int'(hlda_o), 1);
    tick(); check(hlda_o == 1'b1, "R10 grant continues", int'(hlda_o), 1);
    hold_req_i = 1'b0; tick();
    check(hlda_o == 1'b0, "R10 grant ends with request", int'(hlda_o), 0);

    check(exp_q.size() == 0, "R9 every request strobed", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule